// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block brings a clock buffer from supply-off to active outputs. It runs on a free-running reference clock and takes four asynchronous inputs: a supply-valid flag from an analog detector, a single pin that first serves as power-good and afterwards as an active-low power-down, the raw input clock, and the PLL lock flag. Every input first passes through a synchronizer.

The machine has four phases. OFF holds while the supply is invalid. DELAY is a startup wait whose length is a parameter; it is sized to give 0.1 to 0.3 ms at the reference rate. WAIT holds the outputs off until three things are true: the input clock is seen, the pin is high, and the PLL is locked. RUN is the only phase that enables the outputs.

Clock presence comes from counting rising input-clock edges over a fixed window of reference cycles. The first high level on the pin, after the supply becomes valid, gives a one-cycle strobe that latches the frequency and address straps. After that strobe, a low level on the pin is a power-down request.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While reset is applied and just after it, `phase` is 0 (OFF), and `out_en`, `strap_latch` and `pd_req` are all 0.
- R2: A synchronized supply-valid in OFF moves the machine to DELAY (`phase`=1). It stays in DELAY for exactly `DELAY_CYC` reference cycles and then enters WAIT (`phase`=2).
- R3: The cycle after the synchronized supply-valid is seen low, `phase` is OFF, whatever the current phase.
- R4: The machine leaves WAIT for RUN (`phase`=3) only when three conditions hold together: the clock-present flag is set, the synchronized pin is high, and the synchronized PLL lock is high. A missing input clock keeps it in WAIT.
- R5: `out_en` is 1 exactly when `phase` is RUN.
- R6: The clock-present flag is updated only on the last cycle of each `DET_WINDOW`-cycle window. It becomes 1 when that window held at least `DET_MIN_EDGES` rising input-clock edges, and 0 otherwise.
- R7: `strap_latch` pulses for one cycle on the first synchronized high level of the pin while the supply is valid. It does not pulse again until the supply has been lost. After that pulse, `pd_req` equals the inverse of the synchronized pin.
- R8: In RUN, any one of these returns the machine to WAIT on the next cycle: the pin goes low, the clock-present flag clears, or lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold (asynchronous) |
| pg_pd_pin | input | 1 | Power-good at first, then active-low power-down (asynchronous) |
| in_clk | input | 1 | Raw input clock to be detected |
| pll_lock | input | 1 | PLL locked flag (asynchronous) |
| strap_latch | output | 1 | One-cycle strobe to capture the straps |
| pd_req | output | 1 | Power-down request to the output gating |
| out_en | output | 1 | Output enable, set only in RUN |
| phase | output | 2 | Current phase: 0 OFF, 1 DELAY, 2 WAIT, 3 RUN |

## Verification
The assertions check the following on every cycle. Supply loss always forces OFF. DELAY cannot end before its counter is done. RUN is entered only with clock, pin and lock all good, and is left when any of them fails. The strap strobe never lasts two cycles. The presence flag moves only at a window boundary.

Other properties span many cycles, and only the bench scenarios can show them. These are the exact length of DELAY, a strobe that does not repeat across a power-down and return, a strobe that comes back after the supply is cycled, and a presence flag that drops after the input clock stops. The bench reference model tracks these cycle by cycle.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DELAY = 2'd1,
    PH_WAIT  = 2'd2,
    PH_RUN   = 2'd3
  } phase_t;

  // last cycle of a counting window of length win
  function automatic logic window_last(input int unsigned cnt, input int unsigned win);
    return cnt == win - 1;
  endfunction

  // enough input-clock edges seen to call the clock present
  function automatic logic enough_edges(input int unsigned edges, input int unsigned min_edges);
    return edges >= min_edges;
  endfunction
endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrup_clk_detect.sv
module pwrup_clk_detect
  import pwrup_pkg::*;
#(
  parameter int WIN       = 64,
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s,
  output logic present,
  output logic win_end,
  output logic rise
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int EW = $clog2(WIN + 1);

  logic          prev;
  logic [CW-1:0] win_cnt;
  logic [EW-1:0] edges;
  logic [EW-1:0] tally;

  assign rise    = clk_s & ~prev;
  assign tally   = edges + EW'(rise);
  assign win_end = window_last(32'(win_cnt), WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      win_cnt <= '0;
      edges   <= '0;
      present <= 1'b0;
    end else begin
      prev <= clk_s;
      if (win_end) begin
        win_cnt <= '0;
        edges   <= '0;
        present <= enough_edges(32'(tally), MIN_EDGES);
      end else begin
        win_cnt <= win_cnt + 1'b1;
        edges   <= tally;
      end
    end
  end
endmodule

// File: rtl/pwrup_delay.sv
module pwrup_delay #(
  parameter int DELAY_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int DW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;

  logic [DW-1:0] cnt;

  assign done = run && (cnt == DW'(DELAY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end
endmodule

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int DET_WINDOW    = 64,
  parameter int DET_MIN_EDGES = 4,
  parameter int DELAY_CYC     = 25000
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pg_pd_pin,
  input  logic       in_clk,
  input  logic       pll_lock,
  output logic       strap_latch,
  output logic       pd_req,
  output logic       out_en,
  output logic [1:0] phase
);
  logic [3:0] raw_in;
  logic [3:0] syn;
  logic       sup_s, pin_s, lock_s, clk_s;
  logic       present, win_end, rise;
  logic       delay_done;
  logic       pg_seen;
  phase_t     ph, ph_nx;

  assign raw_in = {pll_lock, in_clk, pg_pd_pin, supply_ok};

  pwrup_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign sup_s  = syn[0];
  assign pin_s  = syn[1];
  assign clk_s  = syn[2];
  assign lock_s = syn[3];

  pwrup_clk_detect #(.WIN(DET_WINDOW), .MIN_EDGES(DET_MIN_EDGES)) u_det (
    .clk(ref_clk), .rst_n(rst_n), .clk_s(clk_s),
    .present(present), .win_end(win_end), .rise(rise)
  );

  pwrup_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk(ref_clk), .rst_n(rst_n), .run(ph == PH_DELAY), .done(delay_done)
  );

  always_comb begin
    ph_nx = ph;
    if (!sup_s) ph_nx = PH_OFF;
    else begin
      unique case (ph)
        PH_OFF:   ph_nx = PH_DELAY;
        PH_DELAY: if (delay_done) ph_nx = PH_WAIT;
        PH_WAIT:  if (pin_s && present && lock_s) ph_nx = PH_RUN;
        PH_RUN:   if (!pin_s || !present || !lock_s) ph_nx = PH_WAIT;
        default:  ph_nx = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_OFF;
      pg_seen <= 1'b0;
    end else begin
      ph <= ph_nx;
      if (!sup_s) pg_seen <= 1'b0;
      else if (pin_s) pg_seen <= 1'b1;
    end
  end

  assign strap_latch = sup_s & pin_s & ~pg_seen;
  assign pd_req      = pg_seen & ~pin_s;
  assign out_en      = (ph == PH_RUN);
  assign phase       = ph;
endmodule

// File: rtl/pwrup_seq_checker.sv
module pwrup_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       out_en,
  input logic       strap_latch,
  input logic       pd_req,
  input logic       sup_s,
  input logic       pin_s,
  input logic       lock_s,
  input logic       present,
  input logic       win_end,
  input logic       delay_done
);
  assert_supply_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> phase == 2'd0);

  assert_delay_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && sup_s && !delay_done) |=> phase == 2'd1);

  assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(present && pin_s && lock_s));

  assert_run_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && sup_s && (!pin_s || !present || !lock_s)) |=> phase == 2'd2);

  assert_strap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strap_latch |=> !strap_latch);

  assert_pd_role_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> (!pin_s && !strap_latch));

  assert_present_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(present));

  assert_enable_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd3) |-> !out_en);
endmodule

bind clkbuf_pwrup_seq pwrup_seq_checker u_chk (
  .clk(ref_clk), .rst_n(rst_n), .phase(phase), .out_en(out_en),
  .strap_latch(strap_latch), .pd_req(pd_req), .sup_s(sup_s), .pin_s(pin_s),
  .lock_s(lock_s), .present(present), .win_end(win_end), .delay_done(delay_done)
);

// File: tb/clkbuf_pwrup_seq_bench.sv
`timescale 1ns/1ps
module clkbuf_pwrup_seq_bench;
  localparam int S   = 2;
  localparam int WIN = 16;
  localparam int MIN = 2;
  localparam int DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, pg_pd_pin = 1'b0, in_clk = 1'b0, pll_lock = 1'b0;
  logic strap_latch, pd_req, out_en;
  logic [1:0] phase;

  always #2 clk = ~clk;

  clkbuf_pwrup_seq #(.SYNC_STAGES(S), .DET_WINDOW(WIN), .DET_MIN_EDGES(MIN),
                     .DELAY_CYC(DLY)) u_clkbuf_pwrup_seq (
    .ref_clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_pd_pin(pg_pd_pin),
    .in_clk(in_clk), .pll_lock(pll_lock), .strap_latch(strap_latch),
    .pd_req(pd_req), .out_en(out_en), .phase(phase)
  );

  int vectors = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";
  int strap_cnt = 0;
  bit clk_on = 0;

  // reference model state
  logic [S-1:0] p_sup, p_pin, p_clk, p_lk;
  bit m_prev, m_present, m_seen;
  int m_win, m_edges, m_dly, m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sup = '0; p_pin = '0; p_clk = '0; p_lk = '0;
      m_prev = 0; m_present = 0; m_seen = 0;
      m_win = 0; m_edges = 0; m_dly = 0; m_st = 0;
    end else begin
      bit sup, pin, ck, lk, rise, n_present, n_seen;
      int n_win, n_edges, n_dly, n_st;
      sup = p_sup[S-1]; pin = p_pin[S-1]; ck = p_clk[S-1]; lk = p_lk[S-1];
      rise = ck && !m_prev;
      n_present = m_present;
      if (m_win == WIN-1) begin
        n_present = (m_edges + int'(rise)) >= MIN; n_edges = 0; n_win = 0;
      end else begin
        n_edges = m_edges + int'(rise); n_win = m_win + 1;
      end
      n_dly = (m_st == 1) ? m_dly + 1 : 0;
      n_st = m_st;
      if (!sup) n_st = 0;
      else if (m_st == 0) n_st = 1;
      else if (m_st == 1 && m_dly == DLY-1) n_st = 2;
      else if (m_st == 2 && pin && m_present && lk) n_st = 3;
      else if (m_st == 3 && !(pin && m_present && lk)) n_st = 2;
      n_seen = !sup ? 0 : (m_seen || pin);
      m_prev = ck; m_present = n_present; m_win = n_win; m_edges = n_edges;
      m_dly = n_dly; m_st = n_st; m_seen = n_seen;
      p_sup = {p_sup[S-2:0], supply_ok};
      p_pin = {p_pin[S-2:0], pg_pd_pin};
      p_clk = {p_clk[S-2:0], in_clk};
      p_lk  = {p_lk[S-2:0], pll_lock};
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_phase; bit e_en, e_strap, e_pd;
      e_phase = m_st;
      e_en    = (m_st == 3);
      e_strap = p_sup[S-1] && p_pin[S-1] && !m_seen;
      e_pd    = m_seen && !p_pin[S-1];
      vectors++;
      if (int'(phase) != e_phase || out_en != e_en || strap_latch != e_strap || pd_req != e_pd) begin
        errors++;
        $display("FAIL %s cycle model: phase=%0d en=%0b strap=%0b pd=%0b expected phase=%0d en=%0b strap=%0b pd=%0b",
                 cur_req, phase, out_en, strap_latch, pd_req, e_phase, e_en, e_strap, e_pd);
      end
      if (strap_latch) strap_cnt++;
    end
  end

  // input clock generator: rising edge every 4 reference cycles
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (clk_on) begin
        div++;
        if (div == 2) begin in_clk = ~in_clk; div = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int n_delay;
    // R1: reset state
    cyc(3);
    chk(phase == 2'd0 && !out_en && !strap_latch && !pd_req, "R1", int'(phase), 0);
    rst_n = 1'b1;
    cyc(3);
    chk(phase == 2'd0 && !out_en && !pd_req, "R1", int'(phase), 0);

    // R2: supply up, no clock, pin low; measure DELAY length
    cur_req = "R2";
    supply_ok = 1'b1;
    n_delay = 0;
    repeat (DLY + 20) begin
      @(negedge clk);
      if (phase == 2'd1) n_delay++;
    end
    chk(n_delay == DLY, "R2", n_delay, DLY);
    chk(phase == 2'd2, "R2", int'(phase), 2);

    // R7: first high on pin latches straps once; R4: no clock keeps WAIT
    cur_req = "R7";
    pg_pd_pin = 1'b1;
    pll_lock = 1'b1;
    cyc(60);
    chk(strap_cnt == 1, "R7", strap_cnt, 1);
    cur_req = "R4";
    chk(phase == 2'd2 && !out_en, "R4", int'(phase), 2);

    // R6: clock appears, presence after a window; lock dropped keeps WAIT
    cur_req = "R6";
    pll_lock = 1'b0;
    clk_on = 1;
    cyc(3 * WIN);
    chk(phase == 2'd2, "R4", int'(phase), 2);
    cur_req = "R5";
    pll_lock = 1'b1;
    cyc(8);
    chk(phase == 2'd3 && out_en, "R5", int'(out_en), 1);

    // R8: pin low is power-down; back to WAIT, pd_req set, no new strobe
    cur_req = "R8";
    pg_pd_pin = 1'b0;
    cyc(6);
    chk(phase == 2'd2 && !out_en, "R8", int'(phase), 2);
    chk(pd_req == 1'b1, "R7", int'(pd_req), 1);
    pg_pd_pin = 1'b1;
    cyc(8);
    chk(phase == 2'd3, "R8", int'(phase), 3);
    chk(strap_cnt == 1, "R7", strap_cnt, 1);

    // R8: lock loss leaves RUN
    pll_lock = 1'b0;
    cyc(5);
    chk(phase == 2'd2, "R8", int'(phase), 2);
    pll_lock = 1'b1;
    cyc(5);
    chk(phase == 2'd3, "R5", int'(phase), 3);

    // R6: input clock stops -> presence clears -> WAIT
    cur_req = "R6";
    clk_on = 0;
    cyc(3 * WIN);
    chk(phase == 2'd2 && !out_en, "R6", int'(phase), 2);

    // R3: supply loss returns to OFF from WAIT
    cur_req = "R3";
    supply_ok = 1'b0;
    cyc(5);
    chk(phase == 2'd0 && !pd_req && !strap_latch, "R3", int'(phase), 0);

    // R7: supply back with pin high re-latches straps
    cur_req = "R7";
    supply_ok = 1'b1;
    cyc(10);
    chk(strap_cnt == 2, "R7", strap_cnt, 2);
    clk_on = 1;
    cyc(DLY + 3 * WIN);
    chk(phase == 2'd3 && out_en, "R5", int'(phase), 3);

    // R3: supply loss directly from RUN
    cur_req = "R3";
    supply_ok = 1'b0;
    cyc(4);
    chk(phase == 2'd0 && !out_en, "R3", int'(phase), 0);
    cyc(4);
    finish_run();
  end
endmodule